// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block runs one command on the card's command line. Software or a sequencer hands over a 16-bit command word and a 32-bit argument. The block builds the 48-bit command token, protects it with a CRC7, and shifts it out one bit per SD clock tick. It then listens for the card's answer and checks the answer's CRC and command index when those checks are enabled. It keeps the answer in a 128-bit response register and reports completion and error flags.

The command word is handed over with a valid/ready handshake. `cmd_ready` is high only while no command is in flight. Holding `cmd_valid` high while `cmd_ready` is low does nothing, and the word and argument are taken at the edge where both are high. Two inhibit flags tell the issuer when the command line is in use and when the DAT line is in use. For the busy response type, the DAT line stays occupied until the card releases DAT0.

The card side is a command bit split into output, output enable and input for a pad, plus a DAT0 input. All line activity moves on `sd_tick`, a one-cycle enable that marks each SD clock period.

Top module: `sd_cmd_engine`

## Requirements
- R1: Command word fields are: command index in bits [13:8], data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3, and response kind in bits [1:0]. The response kinds are 00 none, 01 long 136-bit, 10 short 48-bit, and 11 short with busy. `cmd_ready` is high only when no command is in flight. The argument is taken at acceptance.
- R2: The token is sent MSB first on `cmd_o`, one bit per `sd_tick`, for 48 bits in total. Its fields in order are: start bit 0, transmission bit 1, the 6-bit index, the 32-bit argument, a CRC7 with polynomial x^7+x^3+1 over the first 40 bits, and end bit 1. `cmd_oe` is high only while the token is being sent.
- R3: `cmd_o` changes only on a cycle where `sd_tick` is high.
- R4: `inhibit_cmd` rises on acceptance and falls in the cycle where `sts_done` rises.
- R5: With response kind 00, `sts_done` is set after the token and no error flag is set.
- R6: `inhibit_dat` is high during a command whose kind is 11 or whose data-present bit is set. For kind 11, `sts_done` is not set before DAT0 has been seen high after the response.
- R7: A short response puts its 32 content bits in `resp_o[31:0]`, and the upper 96 bits become zero.
- R8: A long response puts frame bits [127:8] in `resp_o[119:0]`, dropping the CRC and end bit. `resp_o[127:120]` becomes zero.
- R9: If no start bit arrives within TIMEOUT_TICKS ticks after the token, the block sets `sts_timeout`, `sts_err` and `sts_done`, and leaves `resp_o` unchanged.
- R10: A response CRC mismatch sets `sts_crc_err` only when CRC checking is enabled.
- R11: An index mismatch in a short response sets `sts_idx_err` only when index checking is enabled. Long responses are never index checked.
- R12: `sts_err` is set whenever any of the timeout, CRC or index error flags is set.
- R13: All status flags clear at the acceptance of the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick | input | 1 | One-cycle enable per SD clock period |
| cmd_valid | input | 1 | Command word and argument valid |
| cmd_ready | output | 1 | Engine idle, so the command can be accepted |
| cmd_word | input | 16 | Command word: index, checks, response kind |
| cmd_arg | input | 32 | Command argument |
| cmd_o | output | 1 | Command line output data |
| cmd_oe | output | 1 | Command line output enable |
| cmd_i | input | 1 | Command line input from the card |
| dat0_i | input | 1 | DAT0 level, low while the card is busy |
| inhibit_cmd | output | 1 | Command in flight |
| inhibit_dat | output | 1 | DAT line occupied by this command |
| resp_o | output | 128 | Stored response |
| sts_done | output | 1 | Command finished |
| sts_timeout | output | 1 | No response started in time |
| sts_crc_err | output | 1 | Response CRC mismatch |
| sts_idx_err | output | 1 | Response index mismatch |
| sts_err | output | 1 | Error summary |

## Verification
The assertions assume that `sd_tick` is never high for two cycles in a row. They also assume that `cmd_i` changes only between ticks, so a response bit is stable at the tick edge that samples it. The bench generates a tick every fourth cycle. The card model changes `cmd_i` and `dat0_i` only at sampling points in the middle of non-tick cycles. For busy commands it pulls DAT0 low before the response start bit, which is the order in which the block expects a busy card.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W    = 6;
  localparam int ARG_W    = 32;
  localparam int CRC_W    = 7;
  localparam int TOKEN_W  = 2 + IDX_W + ARG_W + CRC_W + 1;
  localparam int LONG_W   = 136;
  localparam int RESP_W   = 128;
  localparam int WORD_W   = 16;

  localparam int F_IDX_LSB = 8;
  localparam int F_DPRES   = 5;
  localparam int F_IDXCHK  = 4;
  localparam int F_CRCCHK  = 3;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_kind_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_head(input logic [TOKEN_W-CRC_W-2:0] h);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = TOKEN_W-CRC_W-2; i >= 0; i--) c = crc7_step(c, h[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [TOKEN_W-1:0] token,
  output logic               bit_o,
  output logic               oe_o,
  output logic               done_o
);
  localparam int CW = $clog2(TOKEN_W);

  logic [TOKEN_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      cnt    <= '0;
      act    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        sh  <= token;
        cnt <= '0;
        act <= 1'b1;
      end else if (act && tick) begin
        sh  <= {sh[TOKEN_W-2:0], 1'b1};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(TOKEN_W-1)) begin
          act    <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign bit_o = sh[TOKEN_W-1];
  assign oe_o  = act;
endmodule

// File: rtl/sdc_cmd_rx.sv
module sdc_cmd_rx
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              arm,
  input  logic              long_i,
  input  logic              cmd_i,
  output logic              done_o,
  output logic              tmo_o,
  output logic              crc_ok_o,
  output logic [LONG_W-2:0] frame_o
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  typedef enum logic [1:0] {R_OFF, R_HUNT, R_DATA} rx_st_e;

  rx_st_e           st;
  logic             long_q;
  logic [TW-1:0]    wcnt;
  logic [7:0]       bcnt;
  logic [7:0]       k;
  logic [7:0]       last;
  logic             covered;
  logic [CRC_W-1:0] crc;

  assign k       = bcnt + 8'd1;
  assign last    = long_q ? 8'(LONG_W - 2) : 8'(TOKEN_W - 2);
  assign covered = long_q ? (k >= 8'd8 && k <= 8'd127) : (k <= 8'd39);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= R_OFF;
      long_q   <= 1'b0;
      wcnt     <= '0;
      bcnt     <= '0;
      crc      <= '0;
      frame_o  <= '0;
      done_o   <= 1'b0;
      tmo_o    <= 1'b0;
      crc_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
      case (st)
        R_OFF: if (arm) begin
          st     <= R_HUNT;
          long_q <= long_i;
          wcnt   <= '0;
        end
        R_HUNT: if (tick) begin
          if (!cmd_i) begin
            st   <= R_DATA;
            bcnt <= '0;
            crc  <= '0;
          end else if (wcnt == TW'(TIMEOUT_TICKS - 1)) begin
            st    <= R_OFF;
            tmo_o <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          frame_o <= {frame_o[LONG_W-3:0], cmd_i};
          bcnt    <= k;
          if (covered) crc <= crc7_step(crc, cmd_i);
          if (bcnt == last) begin
            st       <= R_OFF;
            done_o   <= 1'b1;
            crc_ok_o <= (crc == frame_o[CRC_W-1:0]);
          end
        end
        default: st <= R_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [ARG_W-1:0]  cmd_arg,
  output logic              cmd_o,
  output logic              cmd_oe,
  input  logic              cmd_i,
  input  logic              dat0_i,
  output logic              inhibit_cmd,
  output logic              inhibit_dat,
  output logic [RESP_W-1:0] resp_o,
  output logic              sts_done,
  output logic              sts_timeout,
  output logic              sts_crc_err,
  output logic              sts_idx_err,
  output logic              sts_err
);
  typedef enum logic [1:0] {T_IDLE, T_TX, T_RX, T_BUSY} top_st_e;

  top_st_e            st;
  rsp_kind_e          rtype_q;
  logic [IDX_W-1:0]   idx_q;
  logic               crc_en_q, idx_en_q, dp_q;
  logic               accept;
  logic [IDX_W-1:0]   w_idx;
  logic [TOKEN_W-1:0] token;
  logic               tx_done, rx_arm, rx_done, rx_tmo, rx_crc_ok;
  logic [LONG_W-2:0]  rx_frame;
  logic               crc_e, idx_e;
  logic               unused_bits;

  assign cmd_ready   = (st == T_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign w_idx       = cmd_word[F_IDX_LSB +: IDX_W];
  assign token       = {2'b01, w_idx, cmd_arg, crc7_head({2'b01, w_idx, cmd_arg}), 1'b1};
  assign rx_arm      = (st == T_TX) && tx_done && (rtype_q != RSP_NONE);
  assign inhibit_cmd = (st != T_IDLE);
  assign inhibit_dat = (st != T_IDLE) && ((rtype_q == RSP_BUSY) || dp_q);
  assign crc_e       = crc_en_q && !rx_crc_ok;
  assign idx_e       = idx_en_q && (rtype_q != RSP_LONG) && (rx_frame[45:40] != idx_q);
  assign unused_bits = ^{cmd_word[15:14], cmd_word[7:6], cmd_word[2],
                         rx_frame[134:128], rx_frame[7:0]};

  sdc_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(sd_tick), .load(accept), .token(token),
    .bit_o(cmd_o), .oe_o(cmd_oe), .done_o(tx_done)
  );

  sdc_cmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(sd_tick), .arm(rx_arm),
    .long_i(rtype_q == RSP_LONG), .cmd_i(cmd_i), .done_o(rx_done),
    .tmo_o(rx_tmo), .crc_ok_o(rx_crc_ok), .frame_o(rx_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= T_IDLE;
      rtype_q     <= RSP_NONE;
      idx_q       <= '0;
      crc_en_q    <= 1'b0;
      idx_en_q    <= 1'b0;
      dp_q        <= 1'b0;
      resp_o      <= '0;
      sts_done    <= 1'b0;
      sts_timeout <= 1'b0;
      sts_crc_err <= 1'b0;
      sts_idx_err <= 1'b0;
      sts_err     <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (accept) begin
          st          <= T_TX;
          rtype_q     <= rsp_kind_e'(cmd_word[1:0]);
          idx_q       <= w_idx;
          crc_en_q    <= cmd_word[F_CRCCHK];
          idx_en_q    <= cmd_word[F_IDXCHK];
          dp_q        <= cmd_word[F_DPRES];
          sts_done    <= 1'b0;
          sts_timeout <= 1'b0;
          sts_crc_err <= 1'b0;
          sts_idx_err <= 1'b0;
          sts_err     <= 1'b0;
        end
        T_TX: if (tx_done) begin
          if (rtype_q == RSP_NONE) begin
            st       <= T_IDLE;
            sts_done <= 1'b1;
          end else begin
            st <= T_RX;
          end
        end
        T_RX: begin
          if (rx_tmo) begin
            st          <= T_IDLE;
            sts_timeout <= 1'b1;
            sts_err     <= 1'b1;
            sts_done    <= 1'b1;
          end else if (rx_done) begin
            resp_o      <= (rtype_q == RSP_LONG) ? {8'h00, rx_frame[127:8]}
                                                 : {96'h0, rx_frame[39:8]};
            sts_crc_err <= crc_e;
            sts_idx_err <= idx_e;
            sts_err     <= crc_e || idx_e;
            if (rtype_q == RSP_BUSY) begin
              st <= T_BUSY;
            end else begin
              st       <= T_IDLE;
              sts_done <= 1'b1;
            end
          end
        end
        T_BUSY: if (dat0_i) begin
          st       <= T_IDLE;
          sts_done <= 1'b1;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_tick,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_o,
  input logic       cmd_oe,
  input logic       dat0_i,
  input logic       inhibit_cmd,
  input logic       sts_done,
  input logic       sts_timeout,
  input logic       sts_crc_err,
  input logic       sts_idx_err,
  input logic       sts_err,
  input logic [1:0] rtype
);
  AST_OE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> inhibit_cmd); // R2
  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && !sd_tick) |=> $stable(cmd_o)); // R3
  AST_ACCEPT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> inhibit_cmd); // R4
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_done |-> !inhibit_cmd); // R4
  AST_BUSY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_done) && rtype == 2'b11 && !sts_timeout) |-> $past(dat0_i)); // R6
  AST_TIMEOUT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    sts_timeout |-> (rtype != 2'b00)); // R9
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_timeout || sts_crc_err || sts_idx_err) |-> sts_err); // R12
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .dat0_i(dat0_i),
  .inhibit_cmd(inhibit_cmd), .sts_done(sts_done), .sts_timeout(sts_timeout),
  .sts_crc_err(sts_crc_err), .sts_idx_err(sts_idx_err), .sts_err(sts_err),
  .rtype(rtype_q)
);

// File: tb/tb_sd_cmd_engine.sv
`timescale 1ns/1ps
module tb_sd_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0, sd_tick = 1'b0, cmd_valid = 1'b0;
  logic cmd_i = 1'b1, dat0_i = 1'b1;
  logic [15:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         cmd_ready, cmd_o, cmd_oe, inhibit_cmd, inhibit_dat;
  logic [127:0] resp_o;
  logic         sts_done, sts_timeout, sts_crc_err, sts_idx_err, sts_err;

  typedef struct {
    logic [47:0]  token;
    int           len;
    logic [135:0] frame;
    bit           busy;
    int           busy_ticks;
  } card_item_t;

  typedef struct {
    logic [127:0] resp;
    bit           tmo, crc, idx, err;
    string        rtag;
  } exp_item_t;

  card_item_t   card_q[$];
  exp_item_t    exp_q[$];
  logic [127:0] last_resp = '0;
  int           n_chk = 0, n_bad = 0;

  sd_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i), .dat0_i(dat0_i),
    .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat), .resp_o(resp_o),
    .sts_done(sts_done), .sts_timeout(sts_timeout), .sts_crc_err(sts_crc_err),
    .sts_idx_err(sts_idx_err), .sts_err(sts_err)
  );

  always #2 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    sd_tick = 1'b1;
    @(negedge clk);
    sd_tick = 1'b0;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic samp();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_tick();
    do samp(); while (!sd_tick);
  endtask

  function automatic logic [6:0] tb_crc7(input logic [135:0] v, input int n);
    logic [7:0] r;
    r = '0;
    for (int i = n - 1; i >= -7; i--) begin
      r = {r[6:0], (i >= 0) ? v[i] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  // card model: captures the token, answers from the queue
  initial begin
    forever begin
      logic [47:0] tok;
      logic        held;
      bit          hv;
      int          nb;
      card_item_t  it;
      nb = 0;
      hv = 0;
      while (nb < 48) begin
        samp();
        if (cmd_oe) begin
          if (!sd_tick) begin
            held = cmd_o;
            hv = 1;
          end else begin
            if (hv) chk("R3 cmd_o steady between ticks", cmd_o, held);
            tok = {tok[46:0], cmd_o};
            nb++;
            hv = 0;
          end
        end
      end
      samp();
      chk("R2 cmd_oe released after 48 bits", cmd_oe, 0);
      if (card_q.size() == 0) begin
        chk("R2 unexpected token", 1, 0);
      end else begin
        it = card_q.pop_front();
        chk("R2 token", tok, it.token);
        if (it.len > 0) begin
          if (it.busy) dat0_i = 1'b0;
          wait_tick();
          wait_tick();
          samp();
          for (int i = it.len - 1; i >= 0; i--) begin
            cmd_i = it.frame[i];
            wait_tick();
            samp();
          end
          cmd_i = 1'b1;
          if (it.busy) begin
            repeat (it.busy_ticks) wait_tick();
            chk("R6 inhibit_dat while DAT0 low", inhibit_dat, 1);
            chk("R6 no completion while DAT0 low", sts_done, 0);
            dat0_i = 1'b1;
          end
        end
      end
    end
  end

  // monitor: compares each completion with the scoreboard
  initial begin
    bit prev;
    prev = 0;
    forever begin
      samp();
      if (rst_n && sts_done && !prev) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected completion", 1, 0);
        end else begin
          exp_item_t e;
          e = exp_q.pop_front();
          chk({e.rtag, " response register"}, resp_o, e.resp);
          chk("R9 timeout flag", sts_timeout, e.tmo);
          chk("R10 crc error flag", sts_crc_err, e.crc);
          chk("R11 index error flag", sts_idx_err, e.idx);
          chk("R12 error summary", sts_err, e.err);
        end
      end
      prev = sts_done;
    end
  end

  // rmode: 0 silent card, 1 good, 2 corrupted CRC, 3 wrong index
  task automatic issue(input logic [5:0] idx, input logic [1:0] rt, input bit crc_en,
                       input bit idx_en, input bit dp, input logic [31:0] arg,
                       input int rmode, input logic [119:0] body, input int bticks);
    card_item_t  c;
    exp_item_t   e;
    logic [39:0] head;
    logic [5:0]  ridx;
    logic [6:0]  flip;
    head         = {2'b01, idx, arg};
    c.token      = {head, tb_crc7({96'b0, head}, 40), 1'b1};
    c.len        = 0;
    c.busy       = (rt == 2'b11);
    c.busy_ticks = bticks;
    c.frame      = '0;
    flip         = (rmode == 2) ? 7'h01 : 7'h00;
    e.resp = last_resp;
    e.tmo  = 0;
    e.crc  = 0;
    e.idx  = 0;
    e.rtag = "R5";
    if (rt != 2'b00) begin
      if (rmode == 0) begin
        e.tmo  = 1;
        e.rtag = "R9";
      end else if (rt == 2'b01) begin
        c.len   = 136;
        c.frame = {2'b00, 6'h3F, body, tb_crc7({16'b0, body}, 120) ^ flip, 1'b1};
        e.resp  = {8'h00, body};
        e.crc   = crc_en && (rmode == 2);
        e.rtag  = "R8";
      end else begin
        ridx    = (rmode == 3) ? (idx ^ 6'h01) : idx;
        c.len   = 48;
        c.frame = {88'b0, 2'b00, ridx, body[31:0],
                   tb_crc7({96'b0, 2'b00, ridx, body[31:0]}, 40) ^ flip, 1'b1};
        e.resp  = {96'b0, body[31:0]};
        e.crc   = crc_en && (rmode == 2);
        e.idx   = idx_en && (rmode == 3);
        e.rtag  = "R7";
      end
    end
    e.err     = e.tmo | e.crc | e.idx;
    last_resp = e.resp;
    card_q.push_back(c);
    exp_q.push_back(e);
    while (!cmd_ready) samp();
    cmd_word  = {2'b00, idx, 2'b00, dp, idx_en, crc_en, 1'b0, rt};
    cmd_arg   = arg;
    cmd_valid = 1'b1;
    samp();
    cmd_valid = 1'b0;
    cmd_word  = 16'hFFFF;
    cmd_arg   = ~arg;
    chk("R4 inhibit_cmd after acceptance", inhibit_cmd, 1);
    chk("R1 ready low while in flight", cmd_ready, 0);
    chk("R6 inhibit_dat selection", inhibit_dat, (rt == 2'b11) || dp);
    chk("R13 status cleared on acceptance", {sts_done, sts_err, sts_timeout}, 0);
    while (inhibit_cmd) samp();
    chk("R4 done when inhibit_cmd falls", sts_done, 1);
    repeat (3) samp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) samp();
    rst_n = 1'b1;
    samp();
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R4 inhibit_cmd clear after reset", inhibit_cmd, 0);
    chk("R2 cmd_oe low after reset", cmd_oe, 0);
    chk("R5 done clear after reset", sts_done, 0);
    chk("R7 response zero after reset", resp_o, 0);

    issue(6'd0,  2'b00, 0, 0, 0, 32'h0000_0000, 1, '0, 0);                      // R5
    issue(6'd8,  2'b10, 1, 1, 0, 32'h0000_01AA, 1, 120'h0000_01AA, 0);          // R7
    issue(6'd2,  2'b01, 1, 1, 0, 32'h1234_5678, 1,
          120'h1B_4E53_4943_4152_4410_1234_5678_9A, 0);                          // R8, R11
    issue(6'd17, 2'b10, 1, 0, 0, 32'hCAFE_0001, 2, 120'hDEAD_BEEF, 0);          // R10
    issue(6'd17, 2'b10, 0, 0, 0, 32'hCAFE_0002, 2, 120'h5555_AAAA, 0);          // R10 off
    issue(6'd13, 2'b10, 0, 1, 0, 32'h0001_0000, 3, 120'h0000_0900, 0);          // R11
    issue(6'd13, 2'b10, 0, 0, 0, 32'h0001_0000, 3, 120'h0000_0A00, 0);          // R11 off
    issue(6'd7,  2'b11, 1, 1, 0, 32'h0002_0000, 1, 120'h0000_0700, 5);          // R6
    issue(6'd18, 2'b10, 1, 1, 1, 32'h0000_0040, 1, 120'h0000_0900, 0);          // R6 data-present
    issue(6'd55, 2'b10, 1, 1, 0, 32'hFFFF_FFFF, 0, '0, 0);                      // R9
    issue(6'd9,  2'b01, 1, 0, 0, 32'h8000_0001, 2,
          120'hFFEE_DDCC_BBAA_9988_7766_5544_3322, 0);                           // R8 with CRC error
    issue(6'd55, 2'b10, 1, 1, 0, 32'h0000_0000, 1, 120'h0000_0120, 0);          // R13

    repeat (10) samp();
    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule